// File: doc/BRIEF.md
# Partitioned Isochronous Endpoint Buffer

This block holds the received isochronous data of up to sixteen endpoints in one shared 1,024-byte RAM. Firmware places each endpoint's region by writing a 6-bit start value; the value sets RAM address bits 9..4 and the low four bits are zero, so every region begins on a 16-byte boundary. A region runs up to the next higher start value among the enabled endpoints, or to the end of the RAM. The hardware does not check the layout; software keeps the spacing sane.

During a frame the USB side pushes bytes for an endpoint. A start-of-frame pulse closes the frame. For each enabled endpoint it latches the byte count, rewinds the CPU read pointer and restarts the write pointer, records that endpoint's bad-CRC flag, and raises a sticky interrupt flag. The CPU then drains each endpoint one byte per read of that endpoint's data register. There is one RAM port and USB writes have priority over it, so a data read that meets a write is held off for a cycle.

CPU register map (6-bit address, 16-bit data): 0x00+n start value of endpoint n (bits 5..0); 0x10+n data register of endpoint n; 0x20+n latched byte count of endpoint n; 0x30 bit 0 start-of-frame flag; 0x31 CRC error bits (bit n for endpoint n); 0x32 overflow bits (bit n for endpoint n); 0x33 endpoint enable bits (bit n for endpoint n).

Top module: `iso_ep_buffer`

## Requirements
- R1: Writing value v to address 0x00+n sets endpoint n's region base to byte v*16. Reading the same address returns v in bits 5..0.
- R2: Endpoint n's region ends at the smallest start value above its own among enabled endpoints, or at byte 1024. USB writes past that end are dropped, so the latched count never exceeds the region size.
- R3: A start-of-frame pulse sets bit 0 of 0x30. A CPU write with bit 0 at 1 clears it and a write with bit 0 at 0 leaves it unchanged. If a start-of-frame pulse and a clear fall in the same cycle, the flag stays set.
- R4: At start-of-frame each enabled endpoint copies its written byte count to 0x20+n, rewinds its read pointer and restarts its write pointer at zero.
- R5: Each accepted read of 0x10+n returns the next byte of the latched frame, in write order and zero-extended to 16 bits.
- R6: Once the latched count has been read, further reads of 0x10+n return zero.
- R7: At start-of-frame bit n of 0x31 takes the endpoint's bad-CRC input for each enabled endpoint, replacing the previous value. The data of a bad-CRC frame is still readable.
- R8: Bits of 0x33 enable endpoints. A disabled endpoint stores no USB bytes and sets no overflow bit. At start-of-frame its count and CRC bit stay unchanged.
- R9: cpu_ready is low only when a data-register read and a USB write fall in the same cycle. The read completes after the write with the correct byte.
- R10: A USB write in the same cycle as start-of-frame belongs to the new frame. It is not in the count being latched, and it appears as byte 0 of the next frame.
- R11: A dropped write sets bit n of 0x32. The bit stays set across frames until the CPU writes a 1 to it.
- R12: cpu_rvalid and cpu_rdata are valid exactly one cycle after a read is accepted (cpu_rd high with cpu_ready high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_sof | input | 1 | Start-of-frame pulse |
| usb_crc_bad | input | 16 | Per-endpoint bad-CRC flags, sampled at start-of-frame |
| usb_wr_en | input | 1 | USB byte write strobe |
| usb_wr_ep | input | 4 | Endpoint of the USB write |
| usb_wr_data | input | 8 | USB write byte |
| cpu_rd | input | 1 | CPU register read request |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 6 | CPU register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_ready | output | 1 | Read request may be accepted this cycle |

## Verification
Two pairs of functions share a cycle here. The first is a CPU data-register read and a USB byte write, which contend for the single RAM port. The bench holds both requests in one cycle and checks that cpu_ready drops for exactly that cycle. It then checks that the delayed read returns the byte written earlier to the first endpoint, not the byte just written to the second. The second is start-of-frame arriving together with a USB write and a flag-clear write. The bench drives all three on one edge and checks that the flag stays set. It also checks that the latched count leaves out that byte and that the byte opens the following frame.

// File: rtl/iso_buf_pkg.sv
// Package: shared register-map constants for the isochronous buffer.
// Assumes a 6-bit CPU address whose bits 5..4 pick a register group and
// bits 3..0 pick an endpoint (or a control register inside the misc group).
package iso_buf_pkg;
    localparam logic [1:0] GRP_START = 2'd0;
    localparam logic [1:0] GRP_DATA  = 2'd1;
    localparam logic [1:0] GRP_COUNT = 2'd2;
    localparam logic [1:0] GRP_MISC  = 2'd3;

    localparam logic [1:0] MISC_FLAG = 2'd0;
    localparam logic [1:0] MISC_CRC  = 2'd1;
    localparam logic [1:0] MISC_OVF  = 2'd2;
    localparam logic [1:0] MISC_EN   = 2'd3;

    localparam int CPU_DW = 16;
endpackage

// File: rtl/iso_buf_ram.sv
// Module: single-port synchronous byte RAM.
// Assumes that the caller never asserts we and re together; a write stores on
// the edge, and a read presents the addressed byte on rdata after the edge.
module iso_buf_ram #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    // Store a byte on a write, or capture the addressed byte on a read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end else if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/iso_buf_region.sv
// Module: region size of one endpoint inside the shared RAM.
// Assumes starts are in units of 2**GRAN_W bytes. The region ends at the
// lowest higher start value among enabled endpoints, else at the RAM end.
module iso_buf_region #(
    parameter int NUM_EP  = 16,
    parameter int START_W = 6,
    parameter int GRAN_W  = 4,
    parameter int CNT_W   = 11
) (
    input  logic [START_W-1:0] starts [NUM_EP],
    input  logic [NUM_EP-1:0]  en,
    input  logic [START_W-1:0] base,
    output logic [CNT_W-1:0]   size
);
    localparam int SLOTS = 1 << START_W;

    logic [START_W:0] lim;
    logic [CNT_W-1:0] diff;

    // Find the nearest enabled start above base and turn the gap into bytes.
    always_comb begin
        lim = (START_W+1)'(SLOTS);
        for (int i = 0; i < NUM_EP; i++) begin
            if (en[i] && (starts[i] > base) && ({1'b0, starts[i]} < lim)) begin
                lim = {1'b0, starts[i]};
            end
        end
        diff = CNT_W'(lim) - CNT_W'(base);
        size = diff << GRAN_W;
    end
endmodule

// File: rtl/iso_buf_ep_ctx.sv
// Module: per-endpoint frame pointers (write count, latched count, read pointer).
// Assumes wr_hit and rd_hit are only raised for accepted operations.
// At start-of-frame an enabled endpoint latches, rewinds and restarts; a
// write in that same cycle is the new frame's first byte.
module iso_buf_ep_ctx #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             en,
    input  logic             wr_hit,
    input  logic             rd_hit,
    output logic [CNT_W-1:0] wcnt,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rptr
);
    // Advance or restart the pointers of this endpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            cnt  <= '0;
            rptr <= '0;
        end else if (sof && en) begin
            cnt  <= wcnt;
            rptr <= '0;
            wcnt <= wr_hit ? CNT_W'(1) : '0;
        end else begin
            if (wr_hit) wcnt <= wcnt + 1'b1;
            if (rd_hit) rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/iso_ep_buffer.sv
// Module: partitioned isochronous endpoint buffer (top).
// Holds up to sixteen endpoint FIFOs in one RAM. The USB side writes bytes and
// pulses start-of-frame. The CPU side configures, drains and reads status.
// Assumes NUM_EP <= 16 and that cpu_rd and cpu_we are never high together.
module iso_ep_buffer #(
    parameter int NUM_EP    = 16,
    parameter int RAM_BYTES = 1024,
    parameter int GRAN      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_sof,
    input  logic [NUM_EP-1:0] usb_crc_bad,
    input  logic              usb_wr_en,
    input  logic [3:0]        usb_wr_ep,
    input  logic [7:0]        usb_wr_data,
    input  logic              cpu_rd,
    input  logic              cpu_we,
    input  logic [5:0]        cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_ready
);
    import iso_buf_pkg::*;

    localparam int ADDR_W  = $clog2(RAM_BYTES);
    localparam int GRAN_W  = $clog2(GRAN);
    localparam int START_W = ADDR_W - GRAN_W;
    localparam int CNT_W   = ADDR_W + 1;

    logic [START_W-1:0] start_q [NUM_EP];
    logic [NUM_EP-1:0]  en_q, crc_q, ovf_q;
    logic               sof_q;
    logic [CNT_W-1:0]   wcnt [NUM_EP];
    logic [CNT_W-1:0]   cnt  [NUM_EP];
    logic [CNT_W-1:0]   rptr [NUM_EP];
    logic [NUM_EP-1:0]  wr_hit, rd_hit, ovf_set, ovf_clr;

    logic [1:0]         grp;
    logic [3:0]         idx;
    logic               idx_ok, wr_ep_ok, rd_acc;
    logic               wr_go, wr_do, wr_over, rd_do;
    logic [CNT_W-1:0]   wr_off, wr_size;
    logic [ADDR_W-1:0]  wr_addr, rd_addr, ram_addr;
    logic [7:0]         ram_q;
    logic [15:0]        reg_val, reg_q;
    logic               ram_sel_q, rvalid_q;

    assign grp      = cpu_addr[5:4];
    assign idx      = cpu_addr[3:0];
    assign idx_ok   = ({1'b0, idx} < 5'(NUM_EP));
    assign wr_ep_ok = ({1'b0, usb_wr_ep} < 5'(NUM_EP));

    // Hold off a data-register read whenever a USB write owns the RAM port.
    assign cpu_ready = !(cpu_rd && (grp == GRP_DATA) && usb_wr_en);
    assign rd_acc    = cpu_rd && cpu_ready;

    iso_buf_region #(
        .NUM_EP (NUM_EP),
        .START_W(START_W),
        .GRAN_W (GRAN_W),
        .CNT_W  (CNT_W)
    ) u_region (
        .starts(start_q),
        .en    (en_q),
        .base  (start_q[usb_wr_ep]),
        .size  (wr_size)
    );

    // Decide whether the USB byte fits in its endpoint region.
    always_comb begin
        wr_go   = usb_wr_en && wr_ep_ok && en_q[usb_wr_ep];
        wr_off  = usb_sof ? '0 : wcnt[usb_wr_ep];
        wr_do   = wr_go && (wr_off < wr_size);
        wr_over = wr_go && !(wr_off < wr_size);
        wr_addr = {start_q[usb_wr_ep], GRAN_W'(0)} + wr_off[ADDR_W-1:0];
        wr_hit  = '0;
        ovf_set = '0;
        if (wr_do)   wr_hit[usb_wr_ep]  = 1'b1;
        if (wr_over) ovf_set[usb_wr_ep] = 1'b1;
    end

    // Decide whether an accepted data read still has bytes to deliver.
    always_comb begin
        rd_do   = rd_acc && (grp == GRP_DATA) && idx_ok && (rptr[idx] < cnt[idx]);
        rd_addr = {start_q[idx], GRAN_W'(0)} + rptr[idx][ADDR_W-1:0];
        rd_hit  = '0;
        if (rd_do) rd_hit[idx] = 1'b1;
        ram_addr = wr_do ? wr_addr : rd_addr;
    end

    iso_buf_ram #(
        .DEPTH (RAM_BYTES),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk  (clk),
        .we   (wr_do),
        .re   (rd_do),
        .addr (ram_addr),
        .wdata(usb_wr_data),
        .rdata(ram_q)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        iso_buf_ep_ctx #(
            .CNT_W(CNT_W)
        ) u_ctx (
            .clk   (clk),
            .rst_n (rst_n),
            .sof   (usb_sof),
            .en    (en_q[e]),
            .wr_hit(wr_hit[e]),
            .rd_hit(rd_hit[e]),
            .wcnt  (wcnt[e]),
            .cnt   (cnt[e]),
            .rptr  (rptr[e])
        );
    end

    // Select the register value a non-RAM read returns.
    always_comb begin
        reg_val = '0;
        unique case (grp)
            GRP_START: if (idx_ok) reg_val = 16'(start_q[idx]);
            GRP_COUNT: if (idx_ok) reg_val = 16'(cnt[idx]);
            GRP_MISC: begin
                unique case (idx[1:0])
                    MISC_FLAG: reg_val = 16'(sof_q);
                    MISC_CRC:  reg_val = 16'(crc_q);
                    MISC_OVF:  reg_val = 16'(ovf_q);
                    MISC_EN:   reg_val = 16'(en_q);
                endcase
            end
            default: reg_val = '0;
        endcase
    end

    // Overflow bits that the CPU clears with a write of one.
    always_comb begin
        ovf_clr = '0;
        if (cpu_we && (grp == GRP_MISC) && (idx == {2'b00, MISC_OVF})) begin
            ovf_clr = cpu_wdata[NUM_EP-1:0];
        end
    end

    // Configuration registers, status flags and error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_EP; i++) start_q[i] <= '0;
            en_q  <= '0;
            crc_q <= '0;
            ovf_q <= '0;
            sof_q <= 1'b0;
        end else begin
            if (cpu_we && (grp == GRP_START) && idx_ok) begin
                start_q[idx] <= cpu_wdata[START_W-1:0];
            end
            if (cpu_we && (grp == GRP_MISC) && (idx == {2'b00, MISC_EN})) begin
                en_q <= cpu_wdata[NUM_EP-1:0];
            end
            if (usb_sof) begin
                sof_q <= 1'b1;
            end else if (cpu_we && (grp == GRP_MISC) && (idx == {2'b00, MISC_FLAG})
                         && cpu_wdata[0]) begin
                sof_q <= 1'b0;
            end
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
            for (int i = 0; i < NUM_EP; i++) begin
                if (usb_sof && en_q[i]) crc_q[i] <= usb_crc_bad[i];
            end
        end
    end

    // Read-return pipeline: one cycle from acceptance to valid data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q  <= 1'b0;
            ram_sel_q <= 1'b0;
            reg_q     <= '0;
        end else begin
            rvalid_q <= rd_acc;
            if (rd_acc) begin
                ram_sel_q <= rd_do;
                reg_q     <= reg_val;
            end
        end
    end

    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = ram_sel_q ? {8'h00, ram_q} : reg_q;
endmodule

// File: rtl/iso_ep_buffer_chk.sv
// Module: temporal checks on the isochronous buffer, bound to the top.
// Assumes the flag and overflow state are brought in through the bind.
module iso_ep_buffer_chk #(
    parameter int NUM_EP = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usb_sof,
    input logic              usb_wr_en,
    input logic              cpu_rd,
    input logic              cpu_we,
    input logic [5:0]        cpu_addr,
    input logic [15:0]       cpu_wdata,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              sof_flag,
    input logic [NUM_EP-1:0] ovf
);
    assert_stall_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> usb_wr_en);

    assert_sof_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        usb_sof |=> sof_flag);

    assert_zero_write_keeps_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_flag && cpu_we && (cpu_addr == 6'h30) && !cpu_wdata[0]) |=> sof_flag);

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && (cpu_addr == 6'h32)) |=> ((ovf & $past(ovf)) == $past(ovf)));

    assert_rvalid_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_ready) |=> cpu_rvalid);

    assert_no_rvalid_without_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_ready) |=> !cpu_rvalid);
endmodule

bind iso_ep_buffer iso_ep_buffer_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .usb_sof   (usb_sof),
    .usb_wr_en (usb_wr_en),
    .cpu_rd    (cpu_rd),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rvalid(cpu_rvalid),
    .sof_flag  (sof_q),
    .ovf       (ovf_q)
);

// File: tb/iso_ep_buffer_tb.sv
module iso_ep_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usb_sof = 1'b0;
    logic [15:0] usb_crc_bad = '0;
    logic        usb_wr_en = 1'b0;
    logic [3:0]  usb_wr_ep = '0;
    logic [7:0]  usb_wr_data = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_we = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_rvalid;
    logic        cpu_ready;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] crc_m;
    logic [15:0] rd_v;

    always #5 clk = ~clk;

    iso_ep_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .usb_sof(usb_sof), .usb_crc_bad(usb_crc_bad),
        .usb_wr_en(usb_wr_en), .usb_wr_ep(usb_wr_ep), .usb_wr_data(usb_wr_data),
        .cpu_rd(cpu_rd), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .cpu_ready(cpu_ready)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic usb_wr(input logic [3:0] ep, input logic [7:0] d);
        @(negedge clk);
        usb_wr_en = 1'b1; usb_wr_ep = ep; usb_wr_data = d;
        @(negedge clk);
        usb_wr_en = 1'b0;
    endtask

    task automatic sof(input logic [15:0] bad);
        @(negedge clk);
        usb_sof = 1'b1; usb_crc_bad = bad;
        @(negedge clk);
        usb_sof = 1'b0;
    endtask

    task automatic cpu_wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd_t(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = a;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    function automatic logic [7:0] pat_a(input int i, input int j);
        return 8'((i * 17 + j) & 255);
    endfunction

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        cpu_rd_t(6'h30, rd_v); chk("R3 reset flag", rd_v, 16'h0);
        cpu_rd_t(6'h33, rd_v); chk("R8 reset enable", rd_v, 16'h0);
        cpu_rd_t(6'h31, rd_v); chk("R7 reset crc", rd_v, 16'h0);
        cpu_rd_t(6'h32, rd_v); chk("R11 reset ovf", rd_v, 16'h0);
        cpu_rd_t(6'h20, rd_v); chk("R4 reset count", rd_v, 16'h0);
        cpu_rd_t(6'h05, rd_v); chk("R1 reset start", rd_v, 16'h0);

        // Phase A: sixteen 64-byte regions, interleaved fill of 4*i+1 bytes
        for (int i = 0; i < 16; i++) cpu_wr(6'(i), 16'(4 * i));
        cpu_wr(6'h33, 16'hFFFF);
        cpu_rd_t(6'h0F, rd_v); chk("R1 start readback", rd_v, 16'd60);
        for (int j = 0; j < 64; j++) begin
            for (int i = 0; i < 16; i++) begin
                if (j < 4 * i + 1) usb_wr(4'(i), pat_a(i, j));
            end
        end
        sof(16'hA5C3);
        crc_m = 16'hA5C3;
        cpu_rd_t(6'h30, rd_v); chk("R3 flag after sof", rd_v, 16'h1);
        cpu_rd_t(6'h31, rd_v); chk("R7 crc bits", rd_v, crc_m);
        for (int i = 0; i < 16; i++) begin
            cpu_rd_t(6'h20 + 6'(i), rd_v); chk("R4 latched count", rd_v, 16'(4 * i + 1));
        end
        // R7: endpoints flagged bad are still drained with their data
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 4 * i + 1; j++) begin
                cpu_rd_t(6'h10 + 6'(i), rd_v); chk("R5 data order", rd_v, {8'h00, pat_a(i, j)});
            end
            cpu_rd_t(6'h10 + 6'(i), rd_v); chk("R6 past count", rd_v, 16'h0);
            cpu_rd_t(6'h10 + 6'(i), rd_v); chk("R6 past count again", rd_v, 16'h0);
        end
        cpu_rd_t(6'h32, rd_v); chk("R2 no overflow in region", rd_v, 16'h0);
        cpu_wr(6'h30, 16'h0);
        cpu_rd_t(6'h30, rd_v); chk("R3 write zero keeps flag", rd_v, 16'h1);
        cpu_wr(6'h30, 16'h1);
        cpu_rd_t(6'h30, rd_v); chk("R3 write one clears", rd_v, 16'h0);

        // Phase B: ep0 region bounded at 32 bytes by ep1 start 2
        cpu_wr(6'h01, 16'd2);
        cpu_wr(6'h33, 16'h0003);
        for (int j = 0; j < 40; j++) usb_wr(4'd0, 8'(8'h40 + j));
        cpu_rd_t(6'h32, rd_v); chk("R2 overflow bit set", rd_v, 16'h0001);
        sof(16'h0000);
        crc_m = (crc_m & ~16'h0003);
        cpu_rd_t(6'h20, rd_v); chk("R2 count clipped to region", rd_v, 16'd32);
        for (int j = 0; j < 32; j++) begin
            cpu_rd_t(6'h10, rd_v); chk("R2 kept bytes", rd_v, 16'(8'h40 + j));
        end
        cpu_rd_t(6'h10, rd_v); chk("R6 after clipped frame", rd_v, 16'h0);
        cpu_rd_t(6'h31, rd_v); chk("R7 crc replaced", rd_v, crc_m);
        cpu_rd_t(6'h32, rd_v); chk("R11 overflow sticky over sof", rd_v, 16'h0001);
        cpu_wr(6'h32, 16'h0001);
        cpu_rd_t(6'h32, rd_v); chk("R11 overflow cleared", rd_v, 16'h0);
        // disabling ep1 lets ep0 run to the end of RAM
        cpu_wr(6'h33, 16'h0001);
        for (int j = 0; j < 40; j++) usb_wr(4'd0, 8'(8'h80 + j));
        cpu_rd_t(6'h32, rd_v); chk("R2 region widened", rd_v, 16'h0);
        sof(16'h0000);
        crc_m = (crc_m & ~16'h0001);
        cpu_rd_t(6'h20, rd_v); chk("R2 widened count", rd_v, 16'd40);
        for (int j = 0; j < 40; j++) begin
            cpu_rd_t(6'h10, rd_v); chk("R2 widened bytes", rd_v, 16'(8'h80 + j));
        end

        // Phase C: disabled ep1 ignores writes and keeps status
        for (int j = 0; j < 5; j++) usb_wr(4'd1, 8'(j));
        cpu_rd_t(6'h32, rd_v); chk("R8 no overflow on disabled", rd_v, 16'h0);
        sof(16'hFFFF);
        crc_m = (crc_m & ~16'h0001) | 16'h0001;
        cpu_rd_t(6'h21, rd_v); chk("R8 disabled count kept", rd_v, 16'h0);
        cpu_rd_t(6'h31, rd_v); chk("R8 disabled crc kept", rd_v, crc_m);
        cpu_rd_t(6'h20, rd_v); chk("R4 empty frame count", rd_v, 16'h0);
        cpu_rd_t(6'h10, rd_v); chk("R6 empty frame read", rd_v, 16'h0);

        // Phase D: sof, usb write and flag clear in one cycle
        usb_wr(4'd0, 8'h11); usb_wr(4'd0, 8'h22); usb_wr(4'd0, 8'h33);
        @(negedge clk);
        usb_sof = 1'b1; usb_crc_bad = 16'h0;
        usb_wr_en = 1'b1; usb_wr_ep = 4'd0; usb_wr_data = 8'h77;
        cpu_we = 1'b1; cpu_addr = 6'h30; cpu_wdata = 16'h1;
        @(negedge clk);
        usb_sof = 1'b0; usb_wr_en = 1'b0; cpu_we = 1'b0;
        crc_m = crc_m & ~16'h0001;
        cpu_rd_t(6'h30, rd_v); chk("R3 sof beats clear", rd_v, 16'h1);
        cpu_rd_t(6'h20, rd_v); chk("R10 count excludes sof-cycle byte", rd_v, 16'd3);
        sof(16'h0000);
        cpu_rd_t(6'h20, rd_v); chk("R10 byte in next frame", rd_v, 16'd1);
        cpu_rd_t(6'h10, rd_v); chk("R10 byte value", rd_v, 16'h0077);

        // Phase E: data read collides with a write to another endpoint
        cpu_wr(6'h33, 16'h0003);
        usb_wr(4'd0, 8'h5A); usb_wr(4'd0, 8'hA5);
        sof(16'h0000);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 6'h10;
        usb_wr_en = 1'b1; usb_wr_ep = 4'd1; usb_wr_data = 8'hEE;
        #1;
        chk("R9 ready low on collision", 16'(cpu_ready), 16'h0);
        @(negedge clk);
        usb_wr_en = 1'b0;
        #1;
        chk("R9 ready back high", 16'(cpu_ready), 16'h1);
        @(negedge clk);
        cpu_rd = 1'b0;
        chk("R12 rvalid after accept", 16'(cpu_rvalid), 16'h1);
        chk("R9 stalled read data", cpu_rdata, 16'h005A);
        @(negedge clk);
        chk("R12 rvalid drops", 16'(cpu_rvalid), 16'h0);
        cpu_rd_t(6'h10, rd_v); chk("R9 next byte", rd_v, 16'h00A5);
        sof(16'h0000);
        cpu_rd_t(6'h21, rd_v); chk("R9 colliding write stored", rd_v, 16'd1);
        cpu_rd_t(6'h11, rd_v); chk("R9 colliding write data", rd_v, 16'h00EE);

        finish_run();
    end
endmodule